// File: doc/BRIEF.md
# Sparse Row Relative-Index Decoder

This block sits between the index memory of a row-balanced sparse weight store and the input-vector fetch logic. Every nonzero weight is stored with a small relative index: the count of zero columns skipped since the previous nonzero of the same row. The index memory delivers one word per beat. Each word holds one relative index per parallel lane, and these lanes line up with the lanes of the matching weight word. The decoder turns each word into absolute column addresses, one per lane, so the dense input elements that pair with the stored weights can be read.

Every row keeps the same number of nonzeros, so a row spans a fixed number of index words. The decoder keeps a running column base. Within a word it chains the lane values through small adders and then carries the total to the next word. After the last word of a row it clears the base, and it marks that word with an end-of-row flag. The rows of the four gate matrices for one output row lie back to back, so each decoded word also carries a gate tag that steps at every row boundary. An address at or past the row length raises an error flag. Both sides use a valid/ready handshake, and an output register allows one word per cycle.

Top module: `srd_decoder`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1, and the first word accepted decodes from a base of zero.
- R2: Within a word, lane k's address is the base plus lane k's relative index plus the sum of (relative index + 1) over lanes 0..k-1. Lane k occupies bits [k*ADDR_W +: ADDR_W] of `out_addr`, and lane k's relative index occupies bits [k*IDX_W +: IDX_W] of `in_rel`.
- R3: Inside a row, the base for the next word equals the previous word's last lane address plus one.
- R4: Each row holds NNZ_PER_ROW/LANES words. `out_last` is 1 exactly on the final word of each row, and the word that follows decodes from base zero.
- R5: `out_gate` is 0 for the first row after reset. It increases by one at each row boundary and wraps from GATES-1 back to 0.
- R6: `out_err` is 1 on a word when any lane's full address is at least ROW_LEN, and 0 otherwise. An error does not alter the row clearing of R4.
- R7: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is 1 and `out_ready` is 0, all outputs hold their values.
- R8: With `out_ready` held at 1, a new input word is accepted in every cycle.
- R9: On a word without error, lane addresses rise strictly from lane 0 to the last lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An index word is offered |
| in_ready | output | 1 | Decoder can take the word |
| in_rel | input | LANES*IDX_W | Relative indices, lane 0 in the low bits |
| out_valid | output | 1 | Decoded word is present |
| out_ready | input | 1 | Consumer takes the decoded word |
| out_addr | output | LANES*ADDR_W | Absolute column addresses, lane 0 in the low bits |
| out_last | output | 1 | Word closes a row |
| out_gate | output | GW | Gate segment of the row (0..GATES-1) |
| out_err | output | 1 | Some lane addressed past the row |

## Verification
The hardest case to reach is a word whose acceptance and row close fall together with consumer stalls. The base then has to clear exactly once while the output is held, and the next row still has to start at zero. The bench reaches this by sweeping many index patterns under random `out_ready`. A long run of near-exhaustive words puts row boundaries in every stall pattern. The patterns include words whose sums overflow the row, so rows with errors are followed directly by rows without errors.

// File: rtl/srd_pkg.sv
package srd_pkg;
   // Width of a counter or field that must hold values 0..n-1, at least one bit.
   function automatic int srd_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/srd_lane_prefix.sv
module srd_lane_prefix #(
   parameter int LANES = 4,
   parameter int IDX_W = 3,
   parameter int SUM_W = 8
) (
   input  logic [LANES*IDX_W-1:0] rel_i,
   input  logic [SUM_W-1:0]       base_i,
   output logic [LANES*SUM_W-1:0] pos_o,
   output logic [SUM_W-1:0]       next_base_o
);
   // run[k] is the first column lane k may land on
   logic [SUM_W-1:0] run [LANES+1];

   assign run[0] = base_i;

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      logic [SUM_W-1:0] pos_k;
      assign pos_k                    = run[k] + SUM_W'(rel_i[k*IDX_W +: IDX_W]);
      assign run[k+1]                 = pos_k + SUM_W'(1);
      assign pos_o[k*SUM_W +: SUM_W]  = pos_k;
   end

   assign next_base_o = run[LANES];
endmodule

// File: rtl/srd_row_tracker.sv
module srd_row_tracker #(
   parameter int WPR   = 2,
   parameter int GATES = 4
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              step_i,
   output logic                              last_o,
   output logic [srd_pkg::srd_width(GATES)-1:0] gate_o
);
   localparam int CW = srd_pkg::srd_width(WPR);
   localparam int GW = srd_pkg::srd_width(GATES);

   logic [CW-1:0] word_q;
   logic [GW-1:0] gate_q;

   assign last_o = (word_q == CW'(WPR - 1));
   assign gate_o = gate_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         word_q <= '0;
         gate_q <= '0;
      end else if (step_i) begin
         if (last_o) begin
            word_q <= '0;
            gate_q <= (gate_q == GW'(GATES - 1)) ? '0 : gate_q + GW'(1);
         end else begin
            word_q <= word_q + CW'(1);
         end
      end
   end
endmodule

// File: rtl/srd_decoder.sv
module srd_decoder #(
   parameter int LANES       = 4,
   parameter int IDX_W       = 3,
   parameter int ROW_LEN     = 12,
   parameter int NNZ_PER_ROW = 8,
   parameter int GATES       = 4
) (
   input  logic                                       clk,
   input  logic                                       rst_n,
   input  logic                                       in_valid,
   output logic                                       in_ready,
   input  logic [LANES*IDX_W-1:0]                     in_rel,
   output logic                                       out_valid,
   input  logic                                       out_ready,
   output logic [LANES*srd_pkg::srd_width(ROW_LEN)-1:0] out_addr,
   output logic                                       out_last,
   output logic [srd_pkg::srd_width(GATES)-1:0]       out_gate,
   output logic                                       out_err
);
   localparam int ADDR_W = srd_pkg::srd_width(ROW_LEN);
   localparam int GW     = srd_pkg::srd_width(GATES);
   localparam int WPR    = NNZ_PER_ROW / LANES;
   localparam int SPAN_W = $clog2(NNZ_PER_ROW * (2 ** IDX_W) + 1);
   localparam int SUM_W  = ((SPAN_W > ADDR_W) ? SPAN_W : ADDR_W) + 1;

   initial begin
      if (LANES < 1 || IDX_W < 1 || GATES < 1)
         $fatal(1, "srd_decoder: LANES, IDX_W and GATES must be positive");
      if (NNZ_PER_ROW % LANES != 0 || NNZ_PER_ROW < LANES)
         $fatal(1, "srd_decoder: NNZ_PER_ROW must be a nonzero multiple of LANES");
      if (NNZ_PER_ROW > ROW_LEN)
         $fatal(1, "srd_decoder: more nonzeros than columns in a row");
   end

   logic                   accept;
   logic [SUM_W-1:0]       base_q;
   logic [SUM_W-1:0]       next_base;
   logic [LANES*SUM_W-1:0] pos;
   logic                   row_last;
   logic [GW-1:0]          row_gate;
   logic [LANES-1:0]       lane_over;
   logic [LANES*ADDR_W-1:0] addr_d;

   assign in_ready = !out_valid || out_ready;
   assign accept   = in_valid && in_ready;

   srd_lane_prefix #(.LANES(LANES), .IDX_W(IDX_W), .SUM_W(SUM_W)) u_prefix (
      .rel_i       (in_rel),
      .base_i      (base_q),
      .pos_o       (pos),
      .next_base_o (next_base)
   );

   srd_row_tracker #(.WPR(WPR), .GATES(GATES)) u_track (
      .clk    (clk),
      .rst_n  (rst_n),
      .step_i (accept),
      .last_o (row_last),
      .gate_o (row_gate)
   );

   for (genvar k = 0; k < LANES; k++) begin : g_out
      assign lane_over[k]                 = pos[k*SUM_W +: SUM_W] >= SUM_W'(ROW_LEN);
      assign addr_d[k*ADDR_W +: ADDR_W]   = pos[k*SUM_W +: ADDR_W];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         base_q    <= '0;
         out_addr  <= '0;
         out_last  <= 1'b0;
         out_gate  <= '0;
         out_err   <= 1'b0;
      end else if (accept) begin
         out_valid <= 1'b1;
         out_addr  <= addr_d;
         out_last  <= row_last;
         out_gate  <= row_gate;
         out_err   <= |lane_over;
         base_q    <= row_last ? '0 : next_base;
      end else if (out_ready) begin
         out_valid <= 1'b0;
      end
   end
endmodule

// File: rtl/srd_checker.sv
module srd_checker #(
   parameter int LANES       = 4,
   parameter int ADDR_W      = 4,
   parameter int NNZ_PER_ROW = 8,
   parameter int GATES       = 4,
   parameter int GW          = 2
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    in_ready,
   input logic                    out_valid,
   input logic                    out_ready,
   input logic [LANES*ADDR_W-1:0] out_addr,
   input logic                    out_last,
   input logic [GW-1:0]           out_gate,
   input logic                    out_err
);
   localparam int WPR = NNZ_PER_ROW / LANES;
   localparam int CW  = srd_pkg::srd_width(WPR);

   logic          fire;
   logic [CW-1:0] seen_q;
   logic [GW-1:0] exp_gate_q;
   logic          ordered;

   assign fire = out_valid && out_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seen_q     <= '0;
         exp_gate_q <= '0;
      end else if (fire) begin
         if (out_last) begin
            seen_q     <= '0;
            exp_gate_q <= (exp_gate_q == GW'(GATES - 1)) ? '0 : exp_gate_q + GW'(1);
         end else begin
            seen_q <= seen_q + CW'(1);
         end
      end
   end

   always_comb begin
      ordered = 1'b1;
      for (int k = 1; k < LANES; k++)
         if (out_addr[k*ADDR_W +: ADDR_W] <= out_addr[(k-1)*ADDR_W +: ADDR_W])
            ordered = 1'b0;
   end

   a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_last)
                                   && $stable(out_gate) && $stable(out_err));

   a_r7_ready_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> in_ready);

   a_r4_row_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_last == (seen_q == CW'(WPR - 1))));

   a_r5_gate_step: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_gate == exp_gate_q));

   a_r9_lane_order: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_err |-> ordered);
endmodule

bind srd_decoder srd_checker #(
   .LANES       (LANES),
   .ADDR_W      (ADDR_W),
   .NNZ_PER_ROW (NNZ_PER_ROW),
   .GATES       (GATES),
   .GW          (GW)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_ready  (in_ready),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_addr  (out_addr),
   .out_last  (out_last),
   .out_gate  (out_gate),
   .out_err   (out_err)
);

// File: tb/srd_decoder_tb_top.sv
module srd_decoder_tb_top;
   localparam int LANES  = 4;
   localparam int IDX_W  = 3;
   localparam int ROWL   = 12;
   localparam int NNZ    = 8;
   localparam int GATES  = 4;
   localparam int ADDR_W = srd_pkg::srd_width(ROWL);
   localparam int GW     = srd_pkg::srd_width(GATES);
   localparam int WPR    = NNZ / LANES;

   logic                    clk = 1'b0;
   logic                    rst_n = 1'b0;
   logic                    in_valid = 1'b0;
   logic                    in_ready;
   logic [LANES*IDX_W-1:0]  in_rel = '0;
   logic                    out_valid;
   logic                    out_ready = 1'b0;
   logic [LANES*ADDR_W-1:0] out_addr;
   logic                    out_last;
   logic [GW-1:0]           out_gate;
   logic                    out_err;

   always #10 clk = ~clk;

   srd_decoder #(.LANES(LANES), .IDX_W(IDX_W), .ROW_LEN(ROWL),
                 .NNZ_PER_ROW(NNZ), .GATES(GATES)) dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_rel(in_rel), .out_valid(out_valid), .out_ready(out_ready),
      .out_addr(out_addr), .out_last(out_last), .out_gate(out_gate), .out_err(out_err)
   );

   int  checks = 0;
   int  errors = 0;
   bit  done = 0;

   // reference model state
   int  m_base = 0;
   int  m_cnt  = 0;
   int  m_gate = 0;

   logic [LANES*ADDR_W-1:0] q_addr[$];
   bit                      q_last[$];
   bit                      q_err[$];
   int                      q_gate[$];

   bit                      hold_pend = 0;
   logic [LANES*ADDR_W-1:0] h_addr;
   logic                    h_last, h_err;
   logic [GW-1:0]           h_gate;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic model_push(input logic [LANES*IDX_W-1:0] w);
      logic [LANES*ADDR_W-1:0] a;
      int b = m_base;
      bit e = 0;
      bit l = (m_cnt == WPR - 1);
      for (int k = 0; k < LANES; k++) begin
         int p = b + int'(w[k*IDX_W +: IDX_W]);
         a[k*ADDR_W +: ADDR_W] = ADDR_W'(p);
         if (p >= ROWL) e = 1;
         b = p + 1;
      end
      q_addr.push_back(a); q_last.push_back(l); q_err.push_back(e); q_gate.push_back(m_gate);
      if (l) begin
         m_base = 0; m_cnt = 0; m_gate = (m_gate + 1) % GATES;
      end else begin
         m_base = b; m_cnt++;
      end
   endtask

   // One cycle: drive at the falling edge, settle, then observe.
   task automatic cycle_io(input logic [LANES*IDX_W-1:0] w, input bit have,
                           input bit rdy, output bit taken);
      @(negedge clk);
      out_ready = rdy;
      in_valid  = have;
      in_rel    = w;
      #1;
      if (hold_pend) begin
         chk(out_valid && out_addr == h_addr && out_last == h_last &&
             out_gate == h_gate && out_err == h_err, "R7", "held output changed",
             {out_valid, out_addr}, {1'b1, h_addr});
      end
      chk(in_ready == (!out_valid || out_ready), "R7", "in_ready", in_ready,
          !out_valid || out_ready);
      if (out_valid && out_ready) begin
         if (q_addr.size() == 0) begin
            chk(0, "R7", "output with nothing pending", 1, 0);
         end else begin
            logic [LANES*ADDR_W-1:0] ea = q_addr.pop_front();
            bit el = q_last.pop_front();
            bit ee = q_err.pop_front();
            int eg = q_gate.pop_front();
            chk(out_addr == ea, "R2 R3", "lane addresses", out_addr, ea);
            chk(out_last == el, "R4", "end of row", out_last, el);
            chk(int'(out_gate) == eg, "R5", "gate tag", out_gate, eg);
            chk(out_err == ee, "R6", "error flag", out_err, ee);
            if (!ee) begin
               bit inc = 1;
               for (int k = 1; k < LANES; k++)
                  if (out_addr[k*ADDR_W +: ADDR_W] <= out_addr[(k-1)*ADDR_W +: ADDR_W]) inc = 0;
               chk(inc, "R9", "lane order", out_addr, ea);
            end
         end
      end
      hold_pend = out_valid && !out_ready;
      h_addr = out_addr; h_last = out_last; h_gate = out_gate; h_err = out_err;
      taken = have && in_ready;
      if (taken) model_push(w);
   endtask

   // mode 0: consumer always ready, word must go in first try (R8)
   task automatic send(input logic [LANES*IDX_W-1:0] w, input int mode);
      bit taken = 0;
      int tries = 0;
      while (!taken) begin
         cycle_io(w, 1'b1, (mode == 0) ? 1'b1 : 1'($urandom_range(0, 2) != 0), taken);
         tries++;
      end
      if (mode == 0) chk(tries == 1, "R8", "cycles to accept", tries, 1);
   endtask

   task automatic drain();
      bit t;
      int n = 0;
      while ((q_addr.size() != 0 || out_valid) && n < 100) begin
         cycle_io('0, 1'b0, 1'b1, t);
         n++;
      end
      chk(q_addr.size() == 0, "R7", "words left undelivered", q_addr.size(), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
      chk(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);

      // R1/R4/R5/R8: dense rows back to back, first row starts at base 0, gate wraps
      for (int i = 0; i < WPR * (GATES + 2); i++) send('0, 0);
      drain();

      // R6: overflowing row start, then a clean row from zero
      send({LANES{3'd7}}, 0);
      send('0, 0);
      send('0, 0);
      send('0, 0);
      drain();

      // Near-exhaustive sweep of three lanes, fourth lane derived, random stalls (R2 R3 R7)
      for (int v = 0; v < 512; v++) begin
         logic [LANES*IDX_W-1:0] w;
         w[0 +: 3] = 3'(v); w[3 +: 3] = 3'(v >> 3); w[6 +: 3] = 3'(v >> 6);
         w[9 +: 3] = 3'(v * 5);
         send(w, 1);
      end
      drain();

      // Small-gap rows: lane gaps 0/1 from bit pattern, mix of legal and overflowing rows
      for (int v = 0; v < 256; v++) begin
         logic [LANES*IDX_W-1:0] w = '0;
         for (int k = 0; k < LANES; k++) w[k*IDX_W] = v[k];
         send(w, v % 2);
         w = '0;
         for (int k = 0; k < LANES; k++) w[k*IDX_W] = v[k+4];
         send(w, (v / 2) % 2);
      end
      drain();

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not finish actual=1 expected=0");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule